// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns level signals on general-purpose I/O pins into latched interrupt requests. It serves sixteen interrupt lines. Line n watches pin n of one of up to ten I/O ports, and an 8-bit selector field decides which port that is. Each chosen pin is passed through a two-flop synchroniser. The block then compares the synchronised value with its value one clock earlier to find edges.

Software enables rising and falling detection separately on each line, and both may be on at once. A detected edge that is enabled sets a rising or falling pending flag for that line. The flag stays set until software clears it by writing a one to it. A per-line mask decides whether the pending state of a line drives that line's interrupt output. All configuration and status sit in a small register file. It is word addressed, takes a write in a single cycle and returns read data combinationally in the same cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and every bit of `irq_o` is 0. All lines are then masked, no edges are enabled, and every line selects port code 0.
- R2: Word addresses are as follows. Address 0 holds the rising-enable register and address 1 the falling-enable register. Address 2 holds rising-pending and address 3 falling-pending. Address 4 holds the mask. Addresses 8 to 11 hold select registers 0 to 3. Bit n of every per-line register belongs to line n. Unmapped addresses read zero.
- R3: Line n's select field is bits [(n%4)*8+7:(n%4)*8] of select register n/4, and the select registers read back exactly what was written. A code p in 0..9 connects pin n of port p, taken from `gpio_in` bit p*16+n. A code of 10 or more connects no pin, so the line sees a constant 0.
- R4: A 0-to-1 change on a line's selected pin sets its rising-pending bit only if its rising-enable bit is 1. A 1-to-0 change sets its falling-pending bit only if its falling-enable bit is 1. When both enables are on, each edge sets its own flag.
- R5: A pin change that is stable before clock edge k sets the pending flag at edge k+2. The flag is not yet set after edge k+1.
- R6: Writing 1 to a bit of either pending register clears that flag. Writing 0 leaves it unchanged.
- R7: When an enabled edge and a write-one clear reach the same pending bit in the same cycle, the bit ends up set.
- R8: Pending flags are set whatever the mask holds. `irq_o[n]` equals (rising-pending[n] OR falling-pending[n]) AND mask[n].
- R9: Pin changes on ports that a line does not select leave that line's pending flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 160 | Pin levels; port p pin n at bit p*16+n |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| irq_o | output | 16 | Per-line interrupt requests |

## Verification
A register write takes effect at the clock edge where it is sampled, so the bench reads it back at the following falling edge. A pin change applied at a falling edge passes two synchroniser stages and the edge comparison. Its pending flag and `irq_o` therefore appear after the third rising edge, and the bench samples there. The latency test also samples after the second rising edge to confirm that nothing has appeared yet. The same-cycle race test places the clear strobe on exactly that third edge, counting every register on the path.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int EIRQ_LINES  = 16;
    localparam int EIRQ_PORTS  = 10;
    localparam int EIRQ_SEL_W  = 8;
    localparam int EIRQ_DATA_W = 32;
    localparam int EIRQ_ADDR_W = 4;

    // word addresses
    localparam int A_RISE_EN = 0;
    localparam int A_FALL_EN = 1;
    localparam int A_RPEND   = 2;
    localparam int A_FPEND   = 3;
    localparam int A_MASK    = 4;
    localparam int A_SEL0    = 8;
endpackage

// File: rtl/eirq_src_mux.sv
module eirq_src_mux #(
    parameter int NL    = 16,
    parameter int NP    = 10,
    parameter int SEL_W = 8
) (
    input  logic [NP*NL-1:0]    gpio_in,
    input  logic [NL*SEL_W-1:0] sel_flat,
    output logic [NL-1:0]       pin_o
);
    for (genvar n = 0; n < NL; n++) begin : g_line
        logic [SEL_W-1:0] code;
        assign code = sel_flat[n*SEL_W +: SEL_W];
        always_comb begin
            pin_o[n] = 1'b0;
            for (int p = 0; p < NP; p++) begin
                if (code == SEL_W'(p)) pin_o[n] = gpio_in[p*NL+n];
            end
        end
    end
endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det #(
    parameter int NL = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] pin_i,
    output logic [NL-1:0] rise_o,
    output logic [NL-1:0] fall_o
);
    typedef struct packed {
        logic [NL-1:0] s1;
        logic [NL-1:0] s2;
        logic [NL-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
    assign fall_o = ~st_q.s2 & st_q.prev;
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NL     = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NL-1:0]       rise_det,
    input  logic [NL-1:0]       fall_det,
    output logic [DATA_W-1:0]   rdata,
    output logic [NL*SEL_W-1:0] sel_flat,
    output logic [NL-1:0]       rise_en_o,
    output logic [NL-1:0]       fall_en_o,
    output logic [NL-1:0]       rpend_o,
    output logic [NL-1:0]       fpend_o,
    output logic [NL-1:0]       mask_o,
    output logic [NL-1:0]       irq_o
);
    localparam int FIELDS = DATA_W / SEL_W;
    localparam int NSR    = NL / FIELDS;

    typedef struct packed {
        logic [NL-1:0]              rise_en;
        logic [NL-1:0]              fall_en;
        logic [NL-1:0]              rpend;
        logic [NL-1:0]              fpend;
        logic [NL-1:0]              mask;
        logic [NSR-1:0][DATA_W-1:0] sel;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [NL-1:0] clr_r, clr_f;

    always_comb begin
        rg_d  = rg_q;
        clr_r = (wr_en && addr == ADDR_W'(A_RPEND)) ? wdata[NL-1:0] : '0;
        clr_f = (wr_en && addr == ADDR_W'(A_FPEND)) ? wdata[NL-1:0] : '0;
        if (wr_en) begin
            if (addr == ADDR_W'(A_RISE_EN)) rg_d.rise_en = wdata[NL-1:0];
            if (addr == ADDR_W'(A_FALL_EN)) rg_d.fall_en = wdata[NL-1:0];
            if (addr == ADDR_W'(A_MASK))    rg_d.mask    = wdata[NL-1:0];
            for (int k = 0; k < NSR; k++) begin
                if (addr == ADDR_W'(A_SEL0 + k)) rg_d.sel[k] = wdata;
            end
        end
        // detected edge has priority over a same-cycle clear
        rg_d.rpend = (rg_q.rpend & ~clr_r) | (rise_det & rg_q.rise_en);
        rg_d.fpend = (rg_q.fpend & ~clr_f) | (fall_det & rg_q.fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_RISE_EN)) rdata = DATA_W'(rg_q.rise_en);
        if (addr == ADDR_W'(A_FALL_EN)) rdata = DATA_W'(rg_q.fall_en);
        if (addr == ADDR_W'(A_RPEND))   rdata = DATA_W'(rg_q.rpend);
        if (addr == ADDR_W'(A_FPEND))   rdata = DATA_W'(rg_q.fpend);
        if (addr == ADDR_W'(A_MASK))    rdata = DATA_W'(rg_q.mask);
        for (int k = 0; k < NSR; k++) begin
            if (addr == ADDR_W'(A_SEL0 + k)) rdata = rg_q.sel[k];
        end
    end

    assign sel_flat  = rg_q.sel;
    assign rise_en_o = rg_q.rise_en;
    assign fall_en_o = rg_q.fall_en;
    assign rpend_o   = rg_q.rpend;
    assign fpend_o   = rg_q.fpend;
    assign mask_o    = rg_q.mask;
    assign irq_o     = (rg_q.rpend | rg_q.fpend) & rg_q.mask;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NL     = EIRQ_LINES,
    parameter int NP     = EIRQ_PORTS,
    parameter int SEL_W  = EIRQ_SEL_W,
    parameter int DATA_W = EIRQ_DATA_W,
    parameter int ADDR_W = EIRQ_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP*NL-1:0]  gpio_in,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NL-1:0]     irq_o
);
    logic [NL*SEL_W-1:0] sel_flat;
    logic [NL-1:0]       pin_sel, rise_det, fall_det;
    logic [NL-1:0]       rise_en_w, fall_en_w, rpend_w, fpend_w, mask_w;

    eirq_src_mux #(.NL(NL), .NP(NP), .SEL_W(SEL_W)) mux_i (
        .gpio_in  (gpio_in),
        .sel_flat (sel_flat),
        .pin_o    (pin_sel)
    );

    eirq_edge_det #(.NL(NL)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_sel),
        .rise_o (rise_det),
        .fall_o (fall_det)
    );

    eirq_regs #(.NL(NL), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rise_det  (rise_det),
        .fall_det  (fall_det),
        .rdata     (reg_rdata),
        .sel_flat  (sel_flat),
        .rise_en_o (rise_en_w),
        .fall_en_o (fall_en_w),
        .rpend_o   (rpend_w),
        .fpend_o   (fpend_w),
        .mask_o    (mask_w),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
    import eirq_pkg::*;
#(
    parameter int NL     = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NL-1:0]     wdata,
    input logic [NL-1:0]     rise_en,
    input logic [NL-1:0]     fall_en,
    input logic [NL-1:0]     rpend,
    input logic [NL-1:0]     fpend,
    input logic [NL-1:0]     mask,
    input logic [NL-1:0]     irq
);
    // R8: no request on a masked line
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~mask) == '0);

    // R4: rising flag cannot appear on a line whose rising enable was off
    a_r4_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rpend & ~$past(rpend | rise_en)) == '0);

    // R4: falling flag cannot appear on a line whose falling enable was off
    a_r4_fall_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fpend & ~$past(fpend | fall_en)) == '0);

    // R6: a rising flag drops only where a one was written to it
    a_r6_rise_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(rpend) & ~rpend &
                  ~(($past(wr_en) && $past(addr) == ADDR_W'(A_RPEND)) ? $past(wdata) : '0)) == '0);

    // R6: a falling flag drops only where a one was written to it
    a_r6_fall_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(fpend) & ~fpend &
                  ~(($past(wr_en) && $past(addr) == ADDR_W'(A_FPEND)) ? $past(wdata) : '0)) == '0);
endmodule

bind ext_irq_ctrl eirq_checker #(.NL(NL), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata[NL-1:0]),
    .rise_en (rise_en_w),
    .fall_en (fall_en_w),
    .rpend   (rpend_w),
    .fpend   (fpend_w),
    .mask    (mask_w),
    .irq     (irq_o)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
    localparam int NL = 16;
    localparam int NP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0][NL-1:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .gpio_in(pins),
        .reg_wr_en(wr_en), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_o(irq)
    );

    // line, port code, rise en, fall en, drive rising edge, expect rpend, expect fpend
    typedef struct packed {
        logic [3:0] line;
        logic [3:0] port;
        logic re, fe, up, er, ef;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd0,  4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'd9,  4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'd15, 4'd9, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd3,  4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'd7,  4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd12, 4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(a);
        #1 d = rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic quiet();
        wr(0, 0); wr(1, 0); wr(4, 0);
        @(negedge clk); pins = '0;
        cycles(4);
        wr(2, 32'hFFFF); wr(3, 32'hFFFF);
        for (int k = 0; k < 4; k++) wr(8 + k, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        cycles(2);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset irq", 32'(irq), 0);

        // R2 unmapped address reads zero even after writes
        wr(0, 32'hFFFF);
        rd(6, v); chk("R2 unmapped", v, 0);
        rd(0, v); chk("R2 rise enable map", v, 32'hFFFF);
        wr(0, 0);

        // vector table: R3 R4 R8
        for (int i = 0; i < 6; i++) begin
            vec_t t = VECS[i];
            int ln = int'(t.line);
            wr(8 + ln / 4, 32'(t.port) << ((ln % 4) * 8));
            @(negedge clk) pins[t.port][ln] = ~t.up;
            cycles(4);
            wr(0, 32'(t.re) << ln);
            wr(1, 32'(t.fe) << ln);
            wr(4, 32'(1) << ln);
            wr(2, 32'hFFFF); wr(3, 32'hFFFF);
            @(negedge clk) pins[t.port][ln] = t.up;
            cycles(3);
            rd(2, v); chk("R4 rising pending", v, 32'(t.er) << ln);
            rd(3, v); chk("R4 falling pending", v, 32'(t.ef) << ln);
            chk("R8 irq from vector", 32'(irq), 32'(t.er | t.ef) << ln);
            quiet();
        end

        // R3 select read-back and field position
        wr(10, 32'h0000_0500);
        rd(10, v); chk("R3 select readback", v, 32'h0000_0500);
        wr(10, 0);

        // R5 latency
        wr(0, 32'h2); wr(4, 32'h2);
        @(negedge clk) pins[0][1] = 1'b1;
        cycles(2);
        @(negedge clk) chk("R5 not after two edges", 32'(irq), 0);
        @(posedge clk);
        @(negedge clk) chk("R5 set after third edge", 32'(irq), 32'h2);

        // R6 write zero then write one
        wr(2, 32'h0);
        rd(2, v); chk("R6 write zero keeps flag", v, 32'h2);
        wr(2, 32'h2);
        rd(2, v); chk("R6 write one clears", v, 0);
        chk("R6 irq drops", 32'(irq), 0);

        // R7 set wins over same-cycle clear
        @(negedge clk) pins[0][1] = 1'b0;
        cycles(4);
        wr(2, 32'hFFFF);
        @(negedge clk) pins[0][1] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) begin wr_en = 1'b1; addr = 4'd2; wdata = 32'h2; end
        @(posedge clk);
        @(negedge clk) wr_en = 1'b0;
        rd(2, v); chk("R7 set wins", v, 32'h2);
        quiet();

        // R8 mask off: pending sets, irq stays low; unmask raises it
        wr(1, 32'h10);
        @(negedge clk) pins[0][4] = 1'b1;
        cycles(4);
        @(negedge clk) pins[0][4] = 1'b0;
        cycles(3);
        rd(3, v); chk("R8 pending while masked", v, 32'h10);
        chk("R8 masked irq low", 32'(irq), 0);
        wr(4, 32'h10);
        chk("R8 unmasked irq high", 32'(irq), 32'h10);
        quiet();

        // R9 unselected port ignored
        wr(8, 32'h0003_0000);  // line 2 -> port 3
        wr(0, 32'h4); wr(1, 32'h4); wr(4, 32'h4);
        @(negedge clk) pins[1][2] = 1'b1;
        cycles(4);
        rd(2, v); chk("R9 other port rising", v, 0);
        rd(3, v); chk("R9 other port falling", v, 0);
        quiet();

        // R3 code 10 or more connects nothing
        wr(9, 32'h0B00_0000);  // line 7 code 0x0B
        wr(0, 32'h80); wr(4, 32'h80);
        @(negedge clk) for (int p = 0; p < NP; p++) pins[p][7] = 1'b1;
        cycles(4);
        rd(2, v); chk("R3 out-of-range code", v, 0);
        quiet();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule